// File: doc/BRIEF.md
# MMIO Register Window Bridge

This block sits behind a bus slave port that owns a 4 KiB memory-mapped window. It turns each access in that window into cycles on two legacy-style ports of a display controller. One port is a bank of 32 byte-wide I/O registers. The other is an index/data register pair that reaches a small file of 16-bit extension registers.

Software sees both ports as flat memory. An aligned access of 1, 2 or 4 bytes to the legacy sub-range is cut into single-byte port cycles. An access to the extension sub-range becomes one or two halfword transactions. Each of those transactions writes the register index first and then reads or writes the data register.

The bus handshake stays low while the port cycles run. It pulses for one clock when the whole access is finished, and carries the assembled little-endian read data in that same clock. Offsets that map to nothing, and every offset while the configuration enable input is low, complete at once with zero data and no port activity.

Top module: `mmio_reg_bridge`

## Requirements
- R1: Offsets 0x000-0x3FF, 0x420-0x4FF and 0x516-0xFFF map to nothing. An access there starts no port cycle, reads return zero, writes are dropped, and `req_ready` pulses in the clock after acceptance.
- R2: Window offset 0x400+k (k = 0..31) reaches legacy port k. That port is I/O address 0x3C0+k, and `lp_addr` carries k.
- R3: A 2- or 4-byte legacy access becomes 2 or 4 single-byte port cycles on consecutive clocks, with consecutive addresses, lowest address first.
- R4: An extension access at offset 0x500+m uses register index m>>1 (indices 0..10). Every data cycle (`ext_sel`=1) comes right after an index write (`ext_sel`=0, `ext_we`=1), and that index write carries the index in `ext_wdata`.
- R5: A 4-byte extension access makes two index/data transactions, the lower index first, with bytes 0-1 of the bus data mapped to the lower register. If the upper index would be 11, only the lower transaction runs, and read bytes 2-3 are zero.
- R6: A 1-byte extension read runs a full halfword read and returns the addressed byte (offset bit 0 selects the high byte) in `rsp_rdata[7:0]`. A 1-byte extension write runs four cycles in this order: index write, data read, index write, data write. The data written is the value just read with only the addressed byte replaced.
- R7: `req_size` is encoded as 0 for 1 byte, 1 for 2 bytes, and 2 or 3 for 4 bytes. Address bits below the access size are ignored. Access byte k travels in bits [8k+7:8k] of `req_wdata` and `rsp_rdata`, and a write completes with zero read data.
- R8: While `cfg_en` is low, every offset behaves as in R1.
- R9: `req_ready` is low from reset and while port cycles are pending. It is high for exactly one clock, the clock after the last port cycle, and no port is active in that clock.
- R10: `lp_en` and `ext_en` are never high together, and neither is high while no access is in progress.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| cfg_en | input | 1 | Window enable; low leaves every offset undecoded |
| req_valid | input | 1 | Access request, held until `req_ready` |
| req_write | input | 1 | 1 = write, 0 = read |
| req_size | input | 2 | 0: 1 byte, 1: 2 bytes, 2/3: 4 bytes |
| req_addr | input | 12 | Byte offset within the window |
| req_wdata | input | 32 | Write data, little-endian |
| req_ready | output | 1 | One-clock completion pulse |
| rsp_rdata | output | 32 | Assembled read data, valid with `req_ready` |
| lp_en | output | 1 | Legacy byte port cycle strobe |
| lp_we | output | 1 | Legacy cycle is a write |
| lp_addr | output | 5 | Legacy port number (port 0x3C0 + value) |
| lp_wdata | output | 8 | Legacy write byte |
| lp_rdata | input | 8 | Legacy read byte, combinational in the strobe clock |
| ext_en | output | 1 | Extension port cycle strobe |
| ext_we | output | 1 | Extension cycle is a write |
| ext_sel | output | 1 | 0 = index register, 1 = data register |
| ext_wdata | output | 16 | Index value or data to write |
| ext_rdata | input | 16 | Data register contents, combinational in the strobe clock |

## Verification
Legacy reads and writes of every size are issued at both ends of the 32-byte range and with misaligned addresses. They show whether the byte order, the address step and the alignment are right. Extension accesses at index 0, at a middle index and at the last index 10 tell correct index arithmetic apart from off-by-one errors and check the cut of the upper half at the end of the file. Byte writes at both lanes expose a merge that takes the wrong lane or skips the read. Reserved, unmapped, size-3 and disabled-window accesses check that those cases leave the ports silent and return zero.

// File: rtl/mwb_pkg.sv
package mwb_pkg;

    typedef enum logic [1:0] {
        RG_NONE = 2'd0,
        RG_LEG  = 2'd1,
        RG_EXT  = 2'd2
    } region_e;

    typedef enum logic [2:0] {
        ST_IDLE  = 3'd0,
        ST_LEG   = 3'd1,
        ST_XIDX  = 3'd2,
        ST_XDAT  = 3'd3,
        ST_XIDX2 = 3'd4,
        ST_XWR   = 3'd5,
        ST_DONE  = 3'd6
    } state_e;

    localparam logic [1:0] SZ_BYTE = 2'd0;
    localparam logic [1:0] SZ_HALF = 2'd1;

endpackage

// File: rtl/mwb_decode.sv
module mwb_decode
    import mwb_pkg::*;
#(
    parameter int AW        = 12,
    parameter int LEG_BASE  = 'h400,
    parameter int LEG_BYTES = 32,
    parameter int EXT_BASE  = 'h500,
    parameter int EXT_REGS  = 11,
    parameter int XW        = 16
) (
    input  logic          enable,
    input  logic [AW-1:0] offset,
    output region_e       region,
    output logic [AW-1:0] local_off
);
    localparam int LEG_END = LEG_BASE + LEG_BYTES;
    localparam int EXT_END = EXT_BASE + EXT_REGS * (XW / 8);

    always_comb begin
        int o;
        o         = int'(offset);
        region    = RG_NONE;
        local_off = '0;
        if (enable) begin
            if (o >= LEG_BASE && o < LEG_END) begin
                region    = RG_LEG;
                local_off = AW'(o - LEG_BASE);
            end else if (o >= EXT_BASE && o < EXT_END) begin
                region    = RG_EXT;
                local_off = AW'(o - EXT_BASE);
            end
        end
    end

endmodule

// File: rtl/mwb_lane_merge.sv
module mwb_lane_merge #(
    parameter int XW = 16,
    localparam int NL  = XW / 8,
    localparam int LW  = (NL > 1) ? $clog2(NL) : 1
) (
    input  logic [XW-1:0] old_val,
    input  logic [7:0]    byte_in,
    input  logic [LW-1:0] lane,
    output logic [XW-1:0] merged,
    output logic [7:0]    picked
);
    for (genvar g = 0; g < NL; g++) begin : g_lane
        assign merged[8*g +: 8] = (lane == LW'(g)) ? byte_in : old_val[8*g +: 8];
    end

    always_comb begin
        picked = '0;
        for (int i = 0; i < NL; i++) begin
            if (lane == LW'(i)) picked = old_val[8*i +: 8];
        end
    end

endmodule

// File: rtl/mmio_reg_bridge.sv
module mmio_reg_bridge
    import mwb_pkg::*;
#(
    parameter int AW        = 12,
    parameter int DW        = 32,
    parameter int XW        = 16,
    parameter int LEG_BASE  = 'h400,
    parameter int LEG_BYTES = 32,
    parameter int EXT_BASE  = 'h500,
    parameter int EXT_REGS  = 11,
    localparam int LPW = $clog2(LEG_BYTES),
    localparam int NB  = DW / 8,
    localparam int CW  = $clog2(NB),
    localparam int XLW = $clog2(XW / 8)
) (
    input  logic           clk,
    input  logic           rst_n,
    input  logic           cfg_en,
    input  logic           req_valid,
    input  logic           req_write,
    input  logic [1:0]     req_size,
    input  logic [AW-1:0]  req_addr,
    input  logic [DW-1:0]  req_wdata,
    output logic           req_ready,
    output logic [DW-1:0]  rsp_rdata,
    output logic           lp_en,
    output logic           lp_we,
    output logic [LPW-1:0] lp_addr,
    output logic [7:0]     lp_wdata,
    input  logic [7:0]     lp_rdata,
    output logic           ext_en,
    output logic           ext_we,
    output logic           ext_sel,
    output logic [XW-1:0]  ext_wdata,
    input  logic [XW-1:0]  ext_rdata
);

    typedef struct packed {
        state_e        st;
        logic [CW-1:0] cnt;
        logic [CW:0]   nsub;
        logic [AW-1:0] loff;
        logic          wr;
        logic          bytew;
        logic [DW-1:0] wdata;
        logic [DW-1:0] acc;
        logic [XW-1:0] hold;
    } ctx_t;

    ctx_t q, d;

    // request alignment and size
    logic [AW-1:0] aligned;
    logic [CW:0]   nbytes;
    always_comb begin
        case (req_size)
            SZ_BYTE: begin aligned = req_addr;                  nbytes = (CW+1)'(1);  end
            SZ_HALF: begin aligned = req_addr & ~AW'(1);        nbytes = (CW+1)'(2);  end
            default: begin aligned = req_addr & ~AW'(NB - 1);   nbytes = (CW+1)'(NB); end
        endcase
    end

    region_e       dec_region;
    logic [AW-1:0] dec_loff;

    mwb_decode #(
        .AW(AW), .LEG_BASE(LEG_BASE), .LEG_BYTES(LEG_BYTES),
        .EXT_BASE(EXT_BASE), .EXT_REGS(EXT_REGS), .XW(XW)
    ) u_decode (
        .enable   (cfg_en),
        .offset   (aligned),
        .region   (dec_region),
        .local_off(dec_loff)
    );

    // number of halfword transactions, cut at the end of the register file
    logic [CW:0]   ext_nsub;
    logic [AW-1:0] idx0;
    always_comb begin
        idx0     = dec_loff >> XLW;
        ext_nsub = nbytes >> XLW;
        if (ext_nsub == '0) ext_nsub = (CW+1)'(1);
        if (int'(idx0) + int'(ext_nsub) > EXT_REGS)
            ext_nsub = (CW+1)'(EXT_REGS - int'(idx0));
    end

    // per-sub-transaction values
    logic            last;
    logic [LPW-1:0]  leg_addr;
    logic [AW-1:0]   cur_idx;
    logic [7:0]      cur_byte;
    logic [XW-1:0]   cur_half;
    logic [XW-1:0]   merged;
    logic [7:0]      picked;
    logic [XW-1:0]   unused_merge;
    logic [7:0]      unused_pick;

    assign last     = (({1'b0, q.cnt}) + (CW+1)'(1)) == q.nsub;
    assign leg_addr = q.loff[LPW-1:0] + LPW'(q.cnt);
    assign cur_idx  = (q.loff >> XLW) + AW'(q.cnt);
    assign cur_byte = q.wdata[8*q.cnt +: 8];
    assign cur_half = q.wdata[XW*q.cnt +: XW];

    mwb_lane_merge #(.XW(XW)) u_merge (
        .old_val(q.hold),
        .byte_in(q.wdata[7:0]),
        .lane   (q.loff[XLW-1:0]),
        .merged (merged),
        .picked (unused_pick)
    );

    mwb_lane_merge #(.XW(XW)) u_pick (
        .old_val(ext_rdata),
        .byte_in(8'h00),
        .lane   (q.loff[XLW-1:0]),
        .merged (unused_merge),
        .picked (picked)
    );

    always_comb begin
        d         = q;
        lp_en     = 1'b0;
        lp_we     = 1'b0;
        lp_addr   = '0;
        lp_wdata  = '0;
        ext_en    = 1'b0;
        ext_we    = 1'b0;
        ext_sel   = 1'b0;
        ext_wdata = '0;
        req_ready = 1'b0;
        rsp_rdata = '0;

        case (q.st)
            ST_IDLE: begin
                if (req_valid) begin
                    d.cnt   = '0;
                    d.acc   = '0;
                    d.hold  = '0;
                    d.wr    = req_write;
                    d.bytew = (req_size == SZ_BYTE);
                    d.wdata = req_wdata;
                    d.loff  = dec_loff;
                    case (dec_region)
                        RG_LEG: begin
                            d.nsub = nbytes;
                            d.st   = ST_LEG;
                        end
                        RG_EXT: begin
                            d.nsub = ext_nsub;
                            d.st   = ST_XIDX;
                        end
                        default: begin
                            d.nsub = (CW+1)'(1);
                            d.st   = ST_DONE;
                        end
                    endcase
                end
            end

            ST_LEG: begin
                lp_en    = 1'b1;
                lp_we    = q.wr;
                lp_addr  = leg_addr;
                lp_wdata = q.wr ? cur_byte : 8'h00;
                if (!q.wr) d.acc[8*q.cnt +: 8] = lp_rdata;
                if (last) d.st = ST_DONE;
                else      d.cnt = q.cnt + CW'(1);
            end

            ST_XIDX, ST_XIDX2: begin
                ext_en    = 1'b1;
                ext_we    = 1'b1;
                ext_sel   = 1'b0;
                ext_wdata = XW'(cur_idx);
                d.st      = (q.st == ST_XIDX) ? ST_XDAT : ST_XWR;
            end

            ST_XDAT: begin
                ext_en    = 1'b1;
                ext_sel   = 1'b1;
                ext_we    = q.wr && !q.bytew;
                ext_wdata = (q.wr && !q.bytew) ? cur_half : '0;
                if (q.wr && q.bytew) begin
                    d.hold = ext_rdata;
                    d.st   = ST_XIDX2;
                end else begin
                    if (!q.wr) begin
                        if (q.bytew) d.acc[7:0] = picked;
                        else         d.acc[XW*q.cnt +: XW] = ext_rdata;
                    end
                    if (last) begin
                        d.st = ST_DONE;
                    end else begin
                        d.cnt = q.cnt + CW'(1);
                        d.st  = ST_XIDX;
                    end
                end
            end

            ST_XWR: begin
                ext_en    = 1'b1;
                ext_we    = 1'b1;
                ext_sel   = 1'b1;
                ext_wdata = merged;
                d.st      = ST_DONE;
            end

            ST_DONE: begin
                req_ready = 1'b1;
                rsp_rdata = q.acc;
                d.st      = ST_IDLE;
            end

            default: d.st = ST_IDLE;
        endcase
    end

    always_ff @(posedge clk) begin
        if (!rst_n) q <= '0;
        else        q <= d;
    end

endmodule

// File: rtl/mwb_checker.sv
module mwb_checker #(
    parameter int LPW = 5
) (
    input logic           clk,
    input logic           rst_n,
    input logic           req_valid,
    input logic           req_ready,
    input logic           lp_en,
    input logic [LPW-1:0] lp_addr,
    input logic           ext_en,
    input logic           ext_sel
);

    // R10: the two ports are never driven in the same clock
    p_single_port_r10: assert property (@(posedge clk) disable iff (!rst_n)
        !(lp_en && ext_en));

    // R10: port activity only while a request is held
    p_port_needs_req_r10: assert property (@(posedge clk) disable iff (!rst_n)
        (lp_en || ext_en) |-> req_valid);

    // R9: completion is a single-clock pulse
    p_ready_pulse_r9: assert property (@(posedge clk) disable iff (!rst_n)
        req_ready |=> !req_ready);

    // R9: no port cycle in the completion clock
    p_quiet_on_ready_r9: assert property (@(posedge clk) disable iff (!rst_n)
        req_ready |-> (!lp_en && !ext_en));

    // R4: a data cycle always follows an index write
    p_index_first_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (ext_en && ext_sel) |-> $past(ext_en && !ext_sel));

    // R3: back-to-back legacy cycles step the port address by one
    p_leg_step_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (lp_en && $past(lp_en)) |-> (lp_addr == LPW'($past(lp_addr) + 1'b1)));

endmodule

bind mmio_reg_bridge mwb_checker #(.LPW(LPW)) u_chk (
    .clk      (clk),
    .rst_n    (rst_n),
    .req_valid(req_valid),
    .req_ready(req_ready),
    .lp_en    (lp_en),
    .lp_addr  (lp_addr),
    .ext_en   (ext_en),
    .ext_sel  (ext_sel)
);

// File: tb/mmio_reg_bridge_test.sv
module mmio_reg_bridge_test;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        cfg_en = 1'b1;
    logic        req_valid = 1'b0;
    logic        req_write = 1'b0;
    logic [1:0]  req_size = 2'd0;
    logic [11:0] req_addr = '0;
    logic [31:0] req_wdata = '0;
    logic        req_ready;
    logic [31:0] rsp_rdata;
    logic        lp_en, lp_we;
    logic [4:0]  lp_addr;
    logic [7:0]  lp_wdata, lp_rdata;
    logic        ext_en, ext_we, ext_sel;
    logic [15:0] ext_wdata, ext_rdata;

    int total = 0;
    int bad   = 0;

    always #4 clk = ~clk;   // 125 MHz

    mmio_reg_bridge uut (
        .clk(clk), .rst_n(rst_n), .cfg_en(cfg_en),
        .req_valid(req_valid), .req_write(req_write), .req_size(req_size),
        .req_addr(req_addr), .req_wdata(req_wdata),
        .req_ready(req_ready), .rsp_rdata(rsp_rdata),
        .lp_en(lp_en), .lp_we(lp_we), .lp_addr(lp_addr),
        .lp_wdata(lp_wdata), .lp_rdata(lp_rdata),
        .ext_en(ext_en), .ext_we(ext_we), .ext_sel(ext_sel),
        .ext_wdata(ext_wdata), .ext_rdata(ext_rdata)
    );

    // display-controller stand-in
    logic [7:0]  lmem  [32];
    logic [15:0] eregs [16];
    logic [3:0]  eidx;

    assign lp_rdata  = lmem[lp_addr];
    assign ext_rdata = ext_sel ? eregs[eidx] : {12'h000, eidx};

    always @(posedge clk) begin
        if (!rst_n) begin
            for (int i = 0; i < 32; i++) lmem[i] <= 8'hA0 + 8'(i);
            for (int i = 0; i < 16; i++) eregs[i] <= 16'h1000 + 16'(i) * 16'h0111;
            eidx <= '0;
        end else begin
            if (lp_en && lp_we) lmem[lp_addr] <= lp_wdata;
            if (ext_en && ext_we) begin
                if (ext_sel) eregs[eidx] <= ext_wdata;
                else         eidx <= ext_wdata[3:0];
            end
        end
    end

    // one port-side observation: {lp_en, ext_en, ready, we, sel, addr, data}
    typedef logic [36:0] obs_t;

    function automatic obs_t seen();
        obs_t w;
        w = '0;
        w[36] = lp_en;
        w[35] = ext_en;
        w[34] = req_ready;
        if (lp_en) begin
            w[33] = lp_we;
            w[31:16] = {11'h0, lp_addr};
            w[15:0]  = {8'h00, lp_wdata};
        end else if (ext_en) begin
            w[33] = ext_we;
            w[32] = ext_sel;
            w[15:0] = ext_wdata;
        end
        return w;
    endfunction

    function automatic obs_t leg_op(input logic we, input int a, input logic [7:0] dt);
        return {1'b1, 1'b0, 1'b0, we, 1'b0, 16'(a), 8'h00, dt};
    endfunction

    function automatic obs_t ext_op(input logic we, input logic sel, input logic [15:0] dt);
        return {1'b0, 1'b1, 1'b0, we, sel, 16'h0000, dt};
    endfunction

    task automatic chk(input bit ok, input string req, input string what,
                       input logic [39:0] act, input logic [39:0] exp);
        total++;
        if (!ok) begin
            bad++;
            $display("FAIL %s %s act=%h exp=%h", req, what, act, exp);
        end
    endtask

    task automatic access(input logic [11:0] addr, input logic [1:0] size, input logic wr,
                          input logic [31:0] wd, input string req);
        obs_t        ops[$];
        logic [11:0] a;
        int          n, idx, nh;
        logic [31:0] exp;
        logic [15:0] old;
        exp = '0;
        a = (size == 2'd0) ? addr : (size == 2'd1) ? {addr[11:1], 1'b0} : {addr[11:2], 2'b00};
        n = (size == 2'd0) ? 1 : (size == 2'd1) ? 2 : 4;
        if (cfg_en && a >= 12'h400 && a < 12'h420) begin
            for (int k = 0; k < n; k++) begin
                ops.push_back(leg_op(wr, int'(a) - 'h400 + k, wr ? wd[8*k +: 8] : 8'h00));
                if (!wr) exp[8*k +: 8] = lmem[int'(a) - 'h400 + k];
            end
        end else if (cfg_en && a >= 12'h500 && a < 12'h516) begin
            idx = (int'(a) - 'h500) >> 1;
            if (n == 1) begin
                ops.push_back(ext_op(1'b1, 1'b0, 16'(idx)));
                ops.push_back(ext_op(1'b0, 1'b1, 16'h0000));
                old = eregs[idx];
                if (!wr) begin
                    exp[7:0] = a[0] ? old[15:8] : old[7:0];
                end else begin
                    ops.push_back(ext_op(1'b1, 1'b0, 16'(idx)));
                    ops.push_back(ext_op(1'b1, 1'b1, a[0] ? {wd[7:0], old[7:0]} : {old[15:8], wd[7:0]}));
                end
            end else begin
                nh = n / 2;
                for (int k = 0; k < nh; k++) begin
                    if (idx + k < 11) begin
                        ops.push_back(ext_op(1'b1, 1'b0, 16'(idx + k)));
                        ops.push_back(ext_op(wr, 1'b1, wr ? wd[16*k +: 16] : 16'h0000));
                        if (!wr) exp[16*k +: 16] = eregs[idx + k];
                    end
                end
            end
        end

        @(negedge clk);
        req_valid = 1'b1;
        req_write = wr;
        req_size  = size;
        req_addr  = addr;
        req_wdata = wd;
        #1;
        chk(seen() == '0, req, "accept clock not quiet", 40'(seen()), 40'(0));
        foreach (ops[i]) begin
            @(negedge clk);
            chk(seen() == ops[i], req, $sformatf("port cycle %0d", i), 40'(seen()), 40'(ops[i]));
        end
        @(negedge clk);
        chk(seen() == obs_t'(37'h04_0000_0000), req, "completion clock",
            40'(seen()), 40'(37'h04_0000_0000));
        chk(rsp_rdata == exp, req, "read data", 40'(rsp_rdata), 40'(exp));
        req_valid = 1'b0;
        @(negedge clk);
        chk(seen() == '0, "R10", "idle after access", 40'(seen()), 40'(0));
    endtask

    initial begin
        #(8 * 50000);
        bad++;
        total++;
        $display("FAIL watchdog act=%0d exp=%0d", 1, 0);
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin
        repeat (3) @(negedge clk);
        // R9: reset state
        chk(!req_ready && !lp_en && !ext_en, "R9", "outputs during reset",
            40'({req_ready, lp_en, ext_en}), 40'(0));
        rst_n = 1'b1;
        @(negedge clk);
        chk(!req_ready && !lp_en && !ext_en, "R9", "outputs after reset",
            40'({req_ready, lp_en, ext_en}), 40'(0));

        // R2: single legacy bytes at both ends
        access(12'h400, 2'd0, 1'b0, 0, "R2");
        access(12'h41F, 2'd0, 1'b0, 0, "R2");
        access(12'h41F, 2'd0, 1'b1, 32'h0000_005A, "R2");
        access(12'h41F, 2'd0, 1'b0, 0, "R2");
        // R3/R7: word write and read, lowest byte first
        access(12'h404, 2'd2, 1'b1, 32'hDEAD_BEEF, "R3");
        access(12'h404, 2'd2, 1'b0, 0, "R3");
        access(12'h411, 2'd1, 1'b0, 0, "R7");
        access(12'h41E, 2'd3, 1'b0, 0, "R7");
        // R1: reserved and unmapped
        access(12'h010, 2'd2, 1'b0, 0, "R1");
        access(12'h100, 2'd2, 1'b1, 32'h1234_5678, "R1");
        access(12'h420, 2'd0, 1'b0, 0, "R1");
        access(12'h516, 2'd1, 1'b0, 0, "R1");
        access(12'hFFC, 2'd2, 1'b1, 32'hFFFF_FFFF, "R1");
        access(12'h400, 2'd2, 1'b0, 0, "R1");
        // R4: extension halfword indices
        access(12'h500, 2'd1, 1'b0, 0, "R4");
        access(12'h514, 2'd1, 1'b0, 0, "R4");
        access(12'h50B, 2'd1, 1'b1, 32'h0000_C0DE, "R4");
        access(12'h50A, 2'd1, 1'b0, 0, "R4");
        // R5: two halfwords, and the cut at the last register
        access(12'h508, 2'd2, 1'b0, 0, "R5");
        access(12'h502, 2'd2, 1'b1, 32'hAAAA_5555, "R5");
        access(12'h500, 2'd2, 1'b0, 0, "R5");
        access(12'h514, 2'd2, 1'b0, 0, "R5");
        // R6: byte reads and read-modify-write at both lanes
        access(12'h503, 2'd0, 1'b0, 0, "R6");
        access(12'h506, 2'd0, 1'b0, 0, "R6");
        access(12'h505, 2'd0, 1'b1, 32'h0000_0077, "R6");
        access(12'h50E, 2'd0, 1'b1, 32'h0000_0033, "R6");
        access(12'h504, 2'd2, 1'b0, 0, "R6");
        access(12'h50E, 2'd1, 1'b0, 0, "R6");
        // R8: disabled window
        cfg_en = 1'b0;
        access(12'h400, 2'd2, 1'b0, 0, "R8");
        access(12'h400, 2'd2, 1'b1, 32'h0BAD_F00D, "R8");
        access(12'h500, 2'd1, 1'b1, 32'h0000_BEEF, "R8");
        cfg_en = 1'b1;
        access(12'h400, 2'd2, 1'b0, 0, "R8");
        access(12'h500, 2'd1, 1'b0, 0, "R8");

        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

endmodule